// File: doc/BRIEF.md
# Transmit Clock Source Failover Selector

This block picks the transmit timing source for one framer channel. Software sets a source code that names the recovered receive line clock, the transmit serial clock or a divided local oscillator. When the recovered clock is the chosen source and loss monitoring is on, the block watches that clock from the oscillator domain. If the clock goes quiet, transmit timing moves to the divided oscillator. Timing moves back once the recovered clock has been steady again for a while.

The oscillator is divided by 1, 2 or 4 so that the local reference is nominally 12.352 MHz. The matching oscillator inputs are 12.352, 24.704 and 49.408 MHz. The divided reference appears as a one-cycle tick in the oscillator domain. The chosen source appears as a 2-bit select code that drives a clock mux placed outside this block. A status flag shows the loss state. A one-cycle event marks each entry into failover and each exit from it.

A toggle flop clocked by the recovered clock feeds a two-flop synchronizer in the oscillator domain. Each change of the synchronized toggle counts as one sign of activity.

Top module: `txclk_failover`

## Requirements
- R1: `div_sel` picks the divide ratio: 00 gives divide-by-1, so `ref_tick` is high every oscillator cycle; 01 gives divide-by-2, so `ref_tick` is high one cycle in 2; 10 gives divide-by-4, so `ref_tick` is high one cycle in 4.
- R2: `div_sel` = 11 is reserved and acts as divide-by-1.
- R3: While `det_en` = 0, `lost` stays 0 and no failover happens, even when the recovered clock stops.
- R4: Failover starts when all of these hold: `det_en` = 1, `src_sel` = 00 (recovered clock), and `LOSS_TICKS` (32) reference ticks pass with no change of the synchronized toggle. Then `lost` becomes 1 and `eff_src` becomes 10 (divided oscillator).
- R5: While in failover, each toggle change that arrives before the 32-tick window expires is counted. The `GOOD_EDGES`-th (8th) consecutive counted change clears `lost` and returns `eff_src` to 00.
- R6: With `src_sel` = 01 or 10, `eff_src` equals `src_sel` and `lost` stays 0 whatever `det_en` is. `src_sel` = 11 gives `eff_src` = 10. Source codes: 00 = recovered line clock, 01 = transmit serial clock, 10 = divided oscillator.
- R7: A toggle change that arrives after the window has expired counts nothing and restarts the recovery count. Changes spaced more than 32 ticks apart therefore never end failover.
- R8: `fo_evt` is high for exactly one cycle, in the first cycle that `lost` shows its new value, at each entry into failover and at each exit from it.
- R9: A synchronous active-high `rst` clears the divider, the counters and `lost`. After reset, `eff_src` follows the configured source and `fo_evt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Local oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| rclk | input | 1 | Recovered receive line clock |
| src_sel | input | 2 | Configured transmit source code |
| det_en | input | 1 | Loss monitoring enable |
| div_sel | input | 2 | Oscillator divide select |
| ref_tick | output | 1 | Divided reference tick |
| eff_src | output | 2 | Effective transmit source code |
| lost | output | 1 | Recovered clock is lost; failover active |
| fo_evt | output | 1 | One-cycle pulse on failover entry or exit |

## Verification
The hardest state to reach is a recovery attempt that fails: the block must already be in failover, and activity must then come back too slowly to fill the window. The bench first stops the recovered clock to force failover. It then restarts the clock with a half-period of 20 oscillator cycles, so every toggle change lands after the 32-tick window has expired, and it confirms that failover persists. Afterwards it restarts the clock at a fast rate and watches the eight-change return. It repeats the loss under divide-by-4 to confirm that the window is counted in reference ticks and not in oscillator cycles.

// File: rtl/txclk_failover.sv
module txclk_failover #(
  parameter int LOSS_TICKS = 32,
  parameter int GOOD_EDGES = 8
) (
  input  logic       clk_osc,
  input  logic       rst,
  input  logic       rclk,
  input  logic [1:0] src_sel,
  input  logic       det_en,
  input  logic [1:0] div_sel,
  output logic       ref_tick,
  output logic [1:0] eff_src,
  output logic       lost,
  output logic       fo_evt
);
  localparam int GW = $clog2(LOSS_TICKS + 1);
  localparam int HW = (GOOD_EDGES > 1) ? $clog2(GOOD_EDGES) : 1;
  localparam logic [GW-1:0] GAP_MAX = GW'(LOSS_TICKS);
  localparam logic [HW-1:0] GOOD_LAST = HW'(GOOD_EDGES - 1);

  logic          tog;
  logic [2:0]    sync;
  logic [1:0]    cnt, ratio_m1;
  logic [GW-1:0] gap;
  logic [HW-1:0] good;
  logic          lost_d;

  always_ff @(posedge rclk)
    tog <= rst ? 1'b0 : ~tog;

  always_ff @(posedge clk_osc)
    sync <= rst ? 3'b000 : {sync[1:0], tog};

  wire chg      = sync[2] ^ sync[1];
  wire active   = det_en && (src_sel == 2'b00);
  wire gap_full = (gap == GAP_MAX);

  assign ratio_m1 = (div_sel == 2'b01) ? 2'd1 :
                    (div_sel == 2'b10) ? 2'd3 : 2'd0;
  assign ref_tick = (cnt >= ratio_m1);

  always_ff @(posedge clk_osc)
    if (rst || ref_tick) cnt <= 2'd0;
    else                 cnt <= cnt + 2'd1;

  always_ff @(posedge clk_osc) begin
    if (rst || !active) begin
      gap  <= '0;
      good <= '0;
      lost <= 1'b0;
    end else begin
      if (chg)                       gap <= '0;
      else if (ref_tick && !gap_full) gap <= gap + 1'b1;
      if (!lost && gap_full && !chg) lost <= 1'b1;
      if (lost && chg) begin
        if (gap_full) good <= '0;
        else if (good == GOOD_LAST) begin
          good <= '0;
          lost <= 1'b0;
        end else good <= good + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_osc)
    lost_d <= rst ? 1'b0 : lost;

  assign fo_evt  = lost ^ lost_d;
  assign eff_src = (lost || src_sel == 2'b11) ? 2'b10 : src_sel;
endmodule

// File: rtl/txclk_failover_chk.sv
module txclk_failover_chk (
  input logic       clk_osc,
  input logic       rst,
  input logic [1:0] src_sel,
  input logic       det_en,
  input logic [1:0] div_sel,
  input logic       ref_tick,
  input logic [1:0] eff_src,
  input logic       lost,
  input logic       fo_evt
);
  // R1
  div1_tick_chk: assert property (@(posedge clk_osc) disable iff (rst)
    (div_sel == 2'b00) |-> ref_tick);
  // R2
  div_rsvd_tick_chk: assert property (@(posedge clk_osc) disable iff (rst)
    (div_sel == 2'b11) |-> ref_tick);
  // R1
  div2_gap_chk: assert property (@(posedge clk_osc) disable iff (rst)
    (ref_tick && div_sel == 2'b01 && $past(div_sel) == 2'b01) |-> !$past(ref_tick));
  // R3
  no_en_chk: assert property (@(posedge clk_osc) disable iff (rst)
    !det_en |=> !lost);
  // R4
  lost_src_chk: assert property (@(posedge clk_osc) disable iff (rst)
    lost |-> (eff_src == 2'b10));
  // R6
  fixed_src_chk: assert property (@(posedge clk_osc) disable iff (rst)
    (src_sel == 2'b01) |=> (src_sel != 2'b01) || (eff_src == 2'b01 && !lost));
  // R8
  evt_on_change_chk: assert property (@(posedge clk_osc) disable iff (rst)
    (lost != $past(lost)) |-> fo_evt);
  // R8
  evt_only_change_chk: assert property (@(posedge clk_osc) disable iff (rst)
    fo_evt |-> (lost != $past(lost)));
endmodule

bind txclk_failover txclk_failover_chk chk_i (
  .clk_osc(clk_osc), .rst(rst), .src_sel(src_sel), .det_en(det_en),
  .div_sel(div_sel), .ref_tick(ref_tick), .eff_src(eff_src),
  .lost(lost), .fo_evt(fo_evt)
);

// File: tb/txclk_failover_tb_top.sv
`timescale 1ns/1ps
module txclk_failover_tb_top;
  logic clk = 1'b0, rst = 1'b1, rclk = 1'b0, det_en = 1'b0;
  logic [1:0] src_sel = 2'b00, div_sel = 2'b00;
  logic ref_tick, lost, fo_evt;
  logic [1:0] eff_src;

  txclk_failover dut_i (.clk_osc(clk), .rst(rst), .rclk(rclk), .src_sel(src_sel),
    .det_en(det_en), .div_sel(div_sel), .ref_tick(ref_tick), .eff_src(eff_src),
    .lost(lost), .fo_evt(fo_evt));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, ev_cnt = 0, tick_cnt = 0;
  bit done = 0, cmp_on = 0;

  int half = 2, hc = 0;
  bit tog_m = 0;
  always @(posedge clk) begin
    #1;
    if (half > 0) begin
      hc++;
      if (hc >= half) begin hc = 0; rclk = ~rclk; end
    end
  end
  always @(posedge rclk) tog_m = rst ? 1'b0 : ~tog_m;

  int cnt_m = 0, gap_m = 0, good_m = 0, n_m, ng, ngd;
  bit lost_m = 0, lostd_m = 0, tk, ch, nl;
  bit sq[3];

  function automatic int ratio(logic [1:0] d);
    return (d == 2'b01) ? 2 : (d == 2'b10) ? 4 : 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      cnt_m = 0; gap_m = 0; good_m = 0; lost_m = 0; lostd_m = 0;
      sq[0] = 0; sq[1] = 0; sq[2] = 0;
    end else begin
      n_m = ratio(div_sel);
      tk = (cnt_m >= n_m - 1);
      ch = (sq[1] != sq[2]);
      cnt_m = tk ? 0 : cnt_m + 1;
      sq[2] = sq[1]; sq[1] = sq[0]; sq[0] = tog_m;
      lostd_m = lost_m;
      if (!(det_en && src_sel == 2'b00)) begin
        gap_m = 0; good_m = 0; lost_m = 0;
      end else begin
        ng = gap_m; ngd = good_m; nl = lost_m;
        if (ch) ng = 0;
        else if (tk && gap_m < 32) ng = gap_m + 1;
        if (!lost_m && gap_m == 32 && !ch) nl = 1;
        if (lost_m && ch) begin
          if (gap_m == 32) ngd = 0;
          else if (good_m == 7) begin ngd = 0; nl = 0; end
          else ngd = good_m + 1;
        end
        gap_m = ng; good_m = ngd; lost_m = nl;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk("R1 ref_tick", ref_tick, (cnt_m >= ratio(div_sel) - 1));
      chk("R4 eff_src", eff_src, (lost_m || src_sel == 2'b11) ? 2 : src_sel);
      chk("R5 lost", lost, lost_m);
      chk("R8 fo_evt", fo_evt, lost_m ^ lostd_m);
      if (fo_evt) ev_cnt++;
      if (ref_tick) tick_cnt++;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    step(6);
    rst = 0; cmp_on = 1;
    step(1);
    chk("R9 reset lost", lost, 0);
    chk("R9 reset evt", fo_evt, 0);
    chk("R9 reset eff_src", eff_src, 0);

    foreach (div_sel[i]) ;
    for (int d = 0; d < 4; d++) begin
      div_sel = d[1:0];
      step(4);
      tick_cnt = 0;
      step(64);
      if (d == 3) chk("R2 reserved divide ticks", tick_cnt, 64);
      else        chk("R1 divide ticks", tick_cnt, 64 / ratio(d[1:0]));
    end
    div_sel = 2'b00;

    det_en = 0; half = 0;
    step(100);
    chk("R3 disabled no loss", lost, 0);
    chk("R3 disabled eff_src", eff_src, 0);
    half = 2; step(20);

    det_en = 1;
    step(200);
    chk("R4 running clock not lost", lost, 0);
    ev_cnt = 0;
    half = 0;
    step(50);
    chk("R4 loss declared", lost, 1);
    chk("R4 failover source", eff_src, 2);
    chk("R8 entry event count", ev_cnt, 1);

    half = 20;
    step(600);
    chk("R7 slow changes keep failover", lost, 1);
    half = 2;
    step(100);
    chk("R5 recovered", lost, 0);
    chk("R5 source restored", eff_src, 0);
    chk("R8 exit event count", ev_cnt, 2);

    src_sel = 2'b01; half = 0;
    step(100);
    chk("R6 serial source fixed", eff_src, 1);
    chk("R6 serial no loss", lost, 0);
    src_sel = 2'b10;
    step(60);
    chk("R6 osc source fixed", eff_src, 2);
    src_sel = 2'b11;
    step(2);
    chk("R6 code 11 maps to osc", eff_src, 2);

    src_sel = 2'b00; half = 2; step(40);
    div_sel = 2'b10; half = 0;
    step(60);
    chk("R4 divide-4 window not yet expired", lost, 0);
    step(140);
    chk("R4 divide-4 loss declared", lost, 1);
    det_en = 0;
    step(2);
    chk("R3 disable clears failover", lost, 0);
    half = 2;
    step(50);

    rst = 1;
    step(4);
    rst = 0;
    step(1);
    chk("R9 reset after run lost", lost, 0);
    chk("R9 reset after run eff_src", eff_src, 0);
    step(10);
    finish_run();
  end
endmodule